// File: doc/BRIEF.md
# Paged Host Address Window

This block turns the addresses of an external host bus into addresses on a 32-bit internal bus. The host drives a 21-bit address together with a 2-bit segment code. The segment code picks one of four page windows. Each window has three settings: a power-of-two size between 256 bytes and 2 MBytes, a 32-bit offset, and a policy that sets the narrowest host access the page accepts. The host address is first cut down to the selected window's size and then added to that window's offset. The translated address appears one clock later.

The window settings are 16-bit configuration registers. The host reaches them through a register select line that is separate from the memory select line. Only full-word writes, with both byte enables active, change a register. Software sets up each window once through the register select and then uses the memory select for its data traffic. The block forwards an access only when its width meets the page policy. Any narrower access raises an error flag and is not forwarded.

Top module: `host_page_window`

## Requirements
- R1: The segment input selects the window used for a memory access: 00 selects page 0, 01 page 1, 10 page 2 and 11 page 3.
- R2: A memory access (memCs high, cfgCs low, at least one byte enable low) that is permitted sets busValid high on the next clock edge. On that edge busAddr becomes (hostAddr AND (size − 1)) + offset of the selected page, computed in 32 bits. A size of zero gives the full 21-bit window.
- R3: The 32-bit size value of a page is {high half, low half}. Only bits 8 to 21 can be written. Low-half bits 7:0 and high-half bits 15:6 always read as zero, whatever value is written to them.
- R4: The 32-bit offset of a page is {offset high half, offset low half}. Both halves are fully writable.
- R5: A register write (cfgCs and wrEn high) uses hostAddr[5:4] as the page and hostAddr[3:1] as the field. The field codes are 0 size low, 1 size high, 2 offset low, 3 offset high and 4 policy, where the policy uses wrData[1:0]. Field codes 5 to 7 change nothing.
- R6: A register write changes nothing unless both active-low byte enables are 00.
- R7: The host access width is 8 bits if one byte enable is low, 16 bits if both are low, and 32 bits if both are low and hostDword is high. The policy codes are 00 any width, 01 at least 16 bits, and 10 or 11 32 bits only. An access narrower than its page's policy sets accessErr high on the next edge, keeps busValid low and leaves busAddr unchanged.
- R8: While cfgCs is high, no translation takes place. busValid and accessErr are low on the next edge and busAddr holds its value, even if memCs is also high.
- R9: After reset every page has size 256, offset 0 and policy 00. busValid and accessErr are low and busAddr is 0.
- R10: A memory access with both byte enables high (11) produces no busValid and no accessErr, and busAddr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCs | input | 1 | Configuration register select |
| memCs | input | 1 | Memory window select |
| wrEn | input | 1 | Write strobe for register accesses |
| hostSeg | input | 2 | Page select code |
| hostAddr | input | 21 | Host address |
| byteEnN | input | 2 | Active-low byte enables |
| hostDword | input | 1 | Marks a 32-bit host transfer |
| wrData | input | 16 | Register write data |
| busAddr | output | 32 | Translated internal address |
| busValid | output | 1 | Translated address forwarded this cycle |
| accessErr | output | 1 | Access narrower than page policy |

## Verification
The random phase reprograms windows with arbitrary sizes, offsets and policies, including unaligned and non-power-of-two size values. It mixes in byte writes and unused field codes. Each write is followed by accesses with random segments, widths and addresses, so a wrong page decode, a wrong half order or a stray writable bit shows up as a mismatched address. The directed cases cover the reset window, the 256-byte and 2 MB limits, offset carry across the half boundary, and a zero size. They also send accesses that exactly meet or fall one width short of each policy, and accesses with both select lines high, which separate the error path from the register-priority path.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam int NPAGE   = 4;
  localparam int PAGE_W  = $clog2(NPAGE);
  localparam int FIELD_W = 3;

  typedef enum logic [1:0] {W8 = 2'd0, W16 = 2'd1, W32 = 2'd2} widthE;

  typedef enum logic [FIELD_W-1:0] {
    F_RLO = 3'd0, F_RHI = 3'd1, F_OLO = 3'd2, F_OHI = 3'd3, F_CTL = 3'd4
  } fieldE;

  typedef struct packed {
    logic              cfgWr;
    logic [PAGE_W-1:0] cfgPage;
    fieldE             field;
    logic [15:0]       data;
    logic              xlate;
    widthE             hostW;
  } strobeT;
endpackage

// File: rtl/hpw_ctrl.sv
module hpw_ctrl
  import hpw_pkg::*;
#(
  parameter int HOST_AW = 21
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgCs,
  input  logic               memCs,
  input  logic               wrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [1:0]         byteEnN,
  input  logic               hostDword,
  input  logic [15:0]        wrData,
  output strobeT             st
);
  logic fieldOk;
  logic fullWord;

  assign fieldOk  = hostAddr[3:1] <= 3'd4;
  assign fullWord = byteEnN == 2'b00;

  always_comb begin
    st         = '0;
    st.cfgPage = hostAddr[4+PAGE_W-1:4];
    st.field   = fieldE'(hostAddr[3:1]);
    st.data    = wrData;
    st.cfgWr   = cfgCs && wrEn && fullWord && fieldOk;
    st.xlate   = memCs && !cfgCs && (byteEnN != 2'b11);
    if (!fullWord)      st.hostW = W8;
    else if (hostDword) st.hostW = W32;
    else                st.hostW = W16;
  end

  // R8
  cfg_blocks_xlate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgCs |-> !st.xlate);
  // R6
  byte_write_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnN != 2'b00) |-> !st.cfgWr);
endmodule

// File: rtl/hpw_datapath.sv
module hpw_datapath
  import hpw_pkg::*;
#(
  parameter int HOST_AW    = 21,
  parameter int BUS_AW     = 32,
  parameter int MIN_SZ_LOG = 8,
  parameter int MAX_SZ_LOG = 21
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             st,
  input  logic [PAGE_W-1:0]  hostSeg,
  input  logic [HOST_AW-1:0] hostAddr,
  output logic [BUS_AW-1:0]  busAddr,
  output logic               busValid,
  output logic               accessErr
);
  localparam logic [BUS_AW-1:0] KEEP_MASK =
    BUS_AW'(((64'd1 << (MAX_SZ_LOG + 1)) - 64'd1) & ~((64'd1 << MIN_SZ_LOG) - 64'd1));
  localparam logic [BUS_AW-1:0] RESET_SIZE = BUS_AW'(64'd1 << MIN_SZ_LOG);

  logic [BUS_AW-1:0] rangeR [NPAGE];
  logic [BUS_AW-1:0] offsR  [NPAGE];
  logic [1:0]        ctrlR  [NPAGE];

  logic [BUS_AW-1:0] selRange, selOffs, winMask, xAddr;
  widthE             need;
  logic              allowed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NPAGE; p++) begin
        rangeR[p] <= RESET_SIZE;
        offsR[p]  <= '0;
        ctrlR[p]  <= 2'b00;
      end
    end else if (st.cfgWr) begin
      case (st.field)
        F_RLO: rangeR[st.cfgPage][15:0]  <= st.data & KEEP_MASK[15:0];
        F_RHI: rangeR[st.cfgPage][31:16] <= st.data & KEEP_MASK[31:16];
        F_OLO: offsR[st.cfgPage][15:0]   <= st.data;
        F_OHI: offsR[st.cfgPage][31:16]  <= st.data;
        F_CTL: ctrlR[st.cfgPage]         <= st.data[1:0];
        default: ;
      endcase
    end
  end

  assign selRange = rangeR[hostSeg];
  assign selOffs  = offsR[hostSeg];
  assign winMask  = selRange - 1'b1;
  assign xAddr    = (BUS_AW'(hostAddr) & winMask) + selOffs;
  assign need     = (ctrlR[hostSeg] == 2'b00) ? W8 :
                    (ctrlR[hostSeg] == 2'b01) ? W16 : W32;
  assign allowed  = st.hostW >= need;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr   <= '0;
      busValid  <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      busValid  <= st.xlate && allowed;
      accessErr <= st.xlate && !allowed;
      if (st.xlate && allowed) busAddr <= xAddr;
    end
  end

  // R7
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && accessErr));
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> $stable(busAddr));
  // R2
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> $past(st.xlate));

  for (genvar g = 0; g < NPAGE; g++) begin : g_pageChk
    // R6
    offs_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(st.cfgWr && st.cfgPage == PAGE_W'(g)) |=> $stable(offsR[g]));
    // R3
    range_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(st.cfgWr && st.cfgPage == PAGE_W'(g)) |=> $stable(rangeR[g]));
  end
endmodule

// File: rtl/host_page_window.sv
module host_page_window
  import hpw_pkg::*;
#(
  parameter int HOST_AW    = 21,
  parameter int BUS_AW     = 32,
  parameter int MIN_SZ_LOG = 8,
  parameter int MAX_SZ_LOG = 21
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgCs,
  input  logic               memCs,
  input  logic               wrEn,
  input  logic [1:0]         hostSeg,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [1:0]         byteEnN,
  input  logic               hostDword,
  input  logic [15:0]        wrData,
  output logic [BUS_AW-1:0]  busAddr,
  output logic               busValid,
  output logic               accessErr
);
  strobeT st;

  hpw_ctrl #(.HOST_AW(HOST_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgCs(cfgCs), .memCs(memCs), .wrEn(wrEn),
    .hostAddr(hostAddr), .byteEnN(byteEnN), .hostDword(hostDword),
    .wrData(wrData), .st(st)
  );

  hpw_datapath #(
    .HOST_AW(HOST_AW), .BUS_AW(BUS_AW),
    .MIN_SZ_LOG(MIN_SZ_LOG), .MAX_SZ_LOG(MAX_SZ_LOG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .hostSeg(hostSeg), .hostAddr(hostAddr),
    .busAddr(busAddr), .busValid(busValid), .accessErr(accessErr)
  );
endmodule

// File: tb/host_page_window_test.sv
module host_page_window_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgCs = 0, memCs = 0, wrEn = 0, hostDword = 0;
  logic [1:0]  hostSeg = 0, byteEnN = 2'b11;
  logic [20:0] hostAddr = 0;
  logic [15:0] wrData = 0;
  logic [31:0] busAddr;
  logic        busValid, accessErr;

  int checks = 0, errors = 0;
  logic [31:0] mRange [4];
  logic [31:0] mOffs  [4];
  logic [1:0]  mCtrl  [4];
  logic [31:0] lastAddr = 0;

  always #5 clk = ~clk;

  host_page_window uut (
    .clk(clk), .rstN(rstN), .cfgCs(cfgCs), .memCs(memCs), .wrEn(wrEn),
    .hostSeg(hostSeg), .hostAddr(hostAddr), .byteEnN(byteEnN),
    .hostDword(hostDword), .wrData(wrData), .busAddr(busAddr),
    .busValid(busValid), .accessErr(accessErr)
  );

  function automatic logic [31:0] expAddr(input logic [1:0] s, input logic [20:0] a);
    return ({11'd0, a} & (mRange[s] - 32'd1)) + mOffs[s];
  endfunction

  function automatic int widthOf(input logic [1:0] be, input logic dw);
    if (be != 2'b00) return 0;
    return dw ? 2 : 1;
  endfunction

  function automatic int needOf(input logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
  endfunction

  task automatic chk(input string req, input logic v, input logic e, input logic [31:0] a);
    checks++;
    if (busValid !== v || accessErr !== e || busAddr !== a) begin
      errors++;
      $display("FAIL %s: got valid=%0b err=%0b addr=%h, expected valid=%0b err=%0b addr=%h",
               req, busValid, accessErr, busAddr, v, e, a);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] pg, input logic [2:0] fld,
                          input logic [15:0] d, input logic [1:0] be, input logic alsoMem);
    @(negedge clk);
    cfgCs = 1; wrEn = 1; memCs = alsoMem; byteEnN = be; wrData = d;
    hostAddr = {15'd0, pg, fld, 1'b0};
    if (be == 2'b00) begin
      case (fld)
        3'd0: mRange[pg][15:0]  = d & 16'hFF00;
        3'd1: mRange[pg][31:16] = d & 16'h003F;
        3'd2: mOffs[pg][15:0]   = d;
        3'd3: mOffs[pg][31:16]  = d;
        3'd4: mCtrl[pg]         = d[1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R8", 1'b0, 1'b0, lastAddr);
    cfgCs = 0; wrEn = 0; memCs = 0; byteEnN = 2'b11;
  endtask

  task automatic access(input string req, input logic [1:0] s, input logic [20:0] a,
                        input logic [1:0] be, input logic dw);
    logic ev, ee;
    @(negedge clk);
    memCs = 1; hostSeg = s; hostAddr = a; byteEnN = be; hostDword = dw;
    ev = 0; ee = 0;
    if (be != 2'b11) begin
      if (widthOf(be, dw) >= needOf(mCtrl[s])) begin
        ev = 1; lastAddr = expAddr(s, a);
      end else ee = 1;
    end
    @(negedge clk);
    chk(req, ev, ee, lastAddr);
    memCs = 0; byteEnN = 2'b11; hostDword = 0;
  endtask

  task automatic setPage(input logic [1:0] pg, input logic [31:0] sz,
                         input logic [31:0] off, input logic [1:0] pol);
    cfgWrite(pg, 3'd0, sz[15:0], 2'b00, 0);
    cfgWrite(pg, 3'd1, sz[31:16], 2'b00, 0);
    cfgWrite(pg, 3'd2, off[15:0], 2'b00, 0);
    cfgWrite(pg, 3'd3, off[31:16], 2'b00, 0);
    cfgWrite(pg, 3'd4, {14'd0, pol}, 2'b00, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int p = 0; p < 4; p++) begin
      mRange[p] = 32'h100; mOffs[p] = 0; mCtrl[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    chk("R9 reset outputs", 1'b0, 1'b0, 32'd0);
    // R9 reset window: 256 bytes, offset 0
    access("R9", 2'd2, 21'h1ABCD, 2'b10, 0);
    // R1 R4 distinct pages
    setPage(0, 32'h1000, 32'h2000_0000, 0);
    setPage(1, 32'h0001_0000, 32'h1234_FF00, 0);
    setPage(2, 32'h100, 32'h0000_0300, 1);
    setPage(3, 32'h0020_0000, 32'hA000_0000, 2);
    for (int s = 0; s < 4; s++) access("R1", 2'(s), 21'h1F_F3C5, 2'b00, 1);
    // R2 offset carry into high half
    access("R2", 2'd1, 21'h0_FFFF, 2'b00, 0);
    // R3 fixed bits ignored
    cfgWrite(0, 3'd0, 16'hFFFF, 2'b00, 0);
    cfgWrite(0, 3'd1, 16'hFFFF, 2'b00, 0);
    access("R3", 2'd0, 21'h15_5555, 2'b00, 0);
    cfgWrite(0, 3'd1, 16'hFFC0, 2'b00, 0);
    cfgWrite(0, 3'd0, 16'h0000, 2'b00, 0);
    access("R2 zero size", 2'd0, 21'h1F_FFFF, 2'b01, 0);
    // R6 byte writes ignored
    cfgWrite(1, 3'd2, 16'h0BAD, 2'b01, 0);
    cfgWrite(1, 3'd3, 16'h0BAD, 2'b10, 0);
    access("R6", 2'd1, 21'h0_0042, 2'b00, 0);
    // R5 unused field codes
    cfgWrite(2, 3'd5, 16'hFFFF, 2'b00, 0);
    cfgWrite(2, 3'd7, 16'hFFFF, 2'b00, 0);
    access("R5", 2'd2, 21'h0_01FF, 2'b00, 0);
    // R7 policy edges
    access("R7 16 on 16-min", 2'd2, 21'h0_0010, 2'b00, 0);
    access("R7 8 on 16-min", 2'd2, 21'h0_0011, 2'b10, 0);
    access("R7 16 on 32-only", 2'd3, 21'h0_0020, 2'b00, 0);
    access("R7 32 on 32-only", 2'd3, 21'h0_0024, 2'b00, 1);
    cfgWrite(3, 3'd4, 16'h0003, 2'b00, 0);
    access("R7 code 11", 2'd3, 21'h0_0028, 2'b01, 0);
    // R10 no byte enables
    access("R10", 2'd0, 21'h0_1234, 2'b11, 0);
    // R8 both selects
    cfgWrite(0, 3'd2, 16'h4444, 2'b00, 1);
    access("R8 after", 2'd0, 21'h0_0004, 2'b00, 0);
    // random
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 4) == 0)
        cfgWrite(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                 16'($urandom()), ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
                 1'($urandom_range(0, 1)));
      else
        access("R2 random", 2'($urandom_range(0, 3)), 21'($urandom()),
               2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule